// File: doc/BRIEF.md
# Voice Trigger and Debounce Controller

This block sits between a voice player's trigger pins and its playback sequencer. It turns slow, bouncy pin activity into clean one-cycle commands: a start pulse carrying a 5-bit group number, and a stop pulse. Two operating styles are supported. In key style, a combination of up to eight key inputs is matched against a programmable pattern table to select a group, and a separate step button plays the groups one after another. In CPU style, the low five key inputs carry a binary group address that is captured when the strobe input rises.

All pin activity passes through a sample-tick-driven debouncer. Its window is longer while a group is playing, so that retriggers need a steadier input. Each group carries three option bits: edge or level, holdable or unholdable, and retriggerable or not. These decide how key release, repeated presses and end of playback are handled. A stop request input ends playback at once and rewinds the step pointer.

Top module: `voice_trig_ctrl`

## Requirements
- R1: After reset, `start_o` and `stop_o` are low and no group plays until a debounced trigger arrives.
- R2: The combined vector {`sbt`, `keys`} counts as changed only after it has held the same value for DEB_TICKS sample ticks, or RETRIG_TICKS ticks while a group plays. A shorter glitch has no effect.
- R3: In key style (`cpu_mode`=0), a new debounced key vector equal to table entry g (`key_map` bits [8g+7:8g]) pulses `start_o` with `group_o`=g. The all-zero vector never matches, and the lowest matching index wins.
- R4: In CPU style (`cpu_mode`=1), a debounced rise of `sbt` starts the group whose number is `keys[4:0]` (`keys[0]` is the LSB; code 0 is the first group). Bits above 4 are ignored, and key changes alone start nothing.
- R5: In key style, each debounced rise of `sbt` starts the group held in a step pointer that begins at 0. The pointer then advances, and wraps from `seq_last` back to 0.
- R6: While `stop_req` is high, no start is issued. A playing group gets one `stop_o` pulse, and the step pointer returns to 0.
- R7: While a non-retriggerable group plays, new triggers are ignored and do not move the step pointer.
- R8: While a retriggerable group plays, a new trigger issues a fresh `start_o` with the new group and no `stop_o`.
- R9: A holdable group stops with a `stop_o` pulse as soon as its trigger source (its key combination, or `sbt` for step and CPU starts) is no longer active.
- R10: When `play_done` arrives for a level, unholdable group whose trigger is still active, the group restarts. An edge group returns to idle instead.
- R11: `start_o` and `stop_o` are never high in the same cycle. Both are registered, one clock after the deciding input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Sample-rate tick that paces the debouncer |
| stop_req | input | 1 | Immediate stop request |
| cpu_mode | input | 1 | 0 = key style, 1 = CPU strobe style |
| keys | input | 8 | Key inputs (S1 = bit 0) |
| sbt | input | 1 | Step button / address strobe |
| key_map | input | 256 | Pattern table, 8 bits per group |
| opt_edge | input | 32 | Per group: 1 = edge, 0 = level |
| opt_hold | input | 32 | Per group: 1 = holdable |
| opt_retrig | input | 32 | Per group: 1 = retriggerable |
| seq_last | input | 5 | Last group visited by the step pointer |
| play_done | input | 1 | Sequencer reports end of playback |
| start_o | output | 1 | Start pulse |
| group_o | output | 5 | Group number for the start pulse |
| stop_o | output | 1 | Stop pulse |

## Verification
The table pass applies key patterns for low, middle and high table entries. It also applies CPU addresses 0, 31 and one address with the upper key bits set, which separates correct table matching from address decoding and shows that S6–S8 are ignored. Directed cases then drive the step button through a wrap and a stop request, and apply a glitch shorter than the debounce window. They also run each option group: held key with a second press, key release and `play_done` arriving while the key is held. This separates ignore, restart, stop and repeat behaviour.

// File: rtl/vtc_pkg.sv
`timescale 1ns/1ps
package vtc_pkg;
   // origin of the trigger that started the current playback
   typedef enum logic {
      SRC_DIRECT = 1'b0,
      SRC_STEP   = 1'b1
   } vtc_src_e;
endpackage

// File: rtl/vtc_debounce.sv
`timescale 1ns/1ps
module vtc_debounce #(
   parameter int W            = 9,
   parameter int DEB_TICKS    = 128,
   parameter int RETRIG_TICKS = 192
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         long_win,
   input  logic [W-1:0] raw,
   output logic [W-1:0] stable
);
   localparam int CW = $clog2(RETRIG_TICKS + 1);

   logic [W-1:0]  cand;
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   generate
      if (RETRIG_TICKS == DEB_TICKS) begin : g_one_win
         assign lim = CW'(DEB_TICKS);
      end else begin : g_two_win
         assign lim = long_win ? CW'(RETRIG_TICKS) : CW'(DEB_TICKS);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand   <= '0;
         cnt    <= '0;
         stable <= '0;
      end else if (raw != cand) begin
         cand <= raw;
         cnt  <= '0;
      end else if (tick) begin
         if (cnt >= lim - CW'(1)) stable <= cand;
         else                     cnt    <= cnt + CW'(1);
      end
   end

   // R2
   tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stable != $past(stable)) |-> $past(tick));
endmodule

// File: rtl/vtc_keydec.sv
`timescale 1ns/1ps
module vtc_keydec #(
   parameter int N_KEYS   = 8,
   parameter int N_GROUPS = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_KEYS-1:0]            keys,
   input  logic [N_GROUPS*N_KEYS-1:0]   key_map,
   output logic                         hit,
   output logic [$clog2(N_GROUPS)-1:0]  grp
);
   localparam int GW = $clog2(N_GROUPS);

   logic [N_GROUPS-1:0] eq;

   generate
      for (genvar g = 0; g < N_GROUPS; g++) begin : g_cmp
         assign eq[g] = (|keys) && (key_map[g*N_KEYS +: N_KEYS] == keys);
      end
   endgenerate

   always_comb begin
      hit = |eq;
      grp = '0;
      for (int g = N_GROUPS - 1; g >= 0; g--) begin
         if (eq[g]) grp = GW'(g);
      end
   end

   // R3
   zero_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (keys == '0) |-> !hit);
endmodule

// File: rtl/vtc_ctrl.sv
`timescale 1ns/1ps
module vtc_ctrl
   import vtc_pkg::*;
#(
   parameter int N_KEYS   = 8,
   parameter int N_GROUPS = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         stop_req,
   input  logic                         cpu_mode,
   input  logic [N_KEYS-1:0]            db_keys,
   input  logic                         db_sbt,
   input  logic                         hit,
   input  logic [$clog2(N_GROUPS)-1:0]  hit_grp,
   input  logic [N_GROUPS-1:0]          opt_edge,
   input  logic [N_GROUPS-1:0]          opt_hold,
   input  logic [N_GROUPS-1:0]          opt_retrig,
   input  logic [$clog2(N_GROUPS)-1:0]  seq_last,
   input  logic                         play_done,
   output logic                         playing,
   output logic                         start_o,
   output logic [$clog2(N_GROUPS)-1:0]  group_o,
   output logic                         stop_o
);
   localparam int GW = $clog2(N_GROUPS);

   logic [N_KEYS-1:0] k_prev;
   logic              s_prev;
   logic [GW-1:0]     cur_grp, seq_ptr, trig_grp;
   vtc_src_e          cur_src, trig_src;
   logic              key_new, sbt_rise, trig, active;

   always_comb begin
      key_new  = !cpu_mode && hit && (db_keys != k_prev);
      sbt_rise = db_sbt && !s_prev;
      trig     = key_new || sbt_rise;
      trig_src = (!cpu_mode && !key_new) ? SRC_STEP : SRC_DIRECT;
      if (cpu_mode)     trig_grp = db_keys[GW-1:0];
      else if (key_new) trig_grp = hit_grp;
      else              trig_grp = seq_ptr;
      if (cpu_mode || cur_src == SRC_STEP) active = db_sbt;
      else                                 active = hit && (hit_grp == cur_grp);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         k_prev  <= '0;
         s_prev  <= 1'b0;
         playing <= 1'b0;
         cur_grp <= '0;
         cur_src <= SRC_DIRECT;
         seq_ptr <= '0;
         start_o <= 1'b0;
         group_o <= '0;
         stop_o  <= 1'b0;
      end else begin
         k_prev  <= db_keys;
         s_prev  <= db_sbt;
         start_o <= 1'b0;
         stop_o  <= 1'b0;
         if (stop_req) begin
            stop_o  <= playing;
            playing <= 1'b0;
            seq_ptr <= '0;
         end else if (trig && (!playing || opt_retrig[cur_grp])) begin
            start_o <= 1'b1;
            group_o <= trig_grp;
            cur_grp <= trig_grp;
            cur_src <= trig_src;
            playing <= 1'b1;
            if (trig_src == SRC_STEP)
               seq_ptr <= (seq_ptr >= seq_last) ? '0 : seq_ptr + GW'(1);
         end else if (playing && opt_hold[cur_grp] && !active) begin
            stop_o  <= 1'b1;
            playing <= 1'b0;
         end else if (playing && play_done) begin
            if (!opt_edge[cur_grp] && !opt_hold[cur_grp] && active) begin
               start_o <= 1'b1;
               group_o <= cur_grp;
            end else begin
               playing <= 1'b0;
            end
         end
      end
   end

   // R11
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_o && stop_o));
   // R6
   stop_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !start_o);
   // R7
   no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && $past(playing) && !$past(play_done)) |-> $past(opt_retrig[cur_grp]));
   // R9
   release_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(playing) && !$past(stop_req) && !$past(play_done)) |-> stop_o);
endmodule

// File: rtl/voice_trig_ctrl.sv
`timescale 1ns/1ps
module voice_trig_ctrl #(
   parameter int N_KEYS       = 8,
   parameter int N_GROUPS     = 32,
   parameter int DEB_TICKS    = 128,
   parameter int RETRIG_TICKS = 192
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   input  logic                         stop_req,
   input  logic                         cpu_mode,
   input  logic [N_KEYS-1:0]            keys,
   input  logic                         sbt,
   input  logic [N_GROUPS*N_KEYS-1:0]   key_map,
   input  logic [N_GROUPS-1:0]          opt_edge,
   input  logic [N_GROUPS-1:0]          opt_hold,
   input  logic [N_GROUPS-1:0]          opt_retrig,
   input  logic [$clog2(N_GROUPS)-1:0]  seq_last,
   input  logic                         play_done,
   output logic                         start_o,
   output logic [$clog2(N_GROUPS)-1:0]  group_o,
   output logic                         stop_o
);
   localparam int GW = $clog2(N_GROUPS);

   generate
      if (N_KEYS < GW) begin : g_bad_keys
         $error("N_KEYS too narrow for a CPU group address");
      end
      if (DEB_TICKS < 1 || RETRIG_TICKS < DEB_TICKS) begin : g_bad_win
         $error("debounce windows must satisfy 1 <= DEB_TICKS <= RETRIG_TICKS");
      end
   endgenerate

   logic [N_KEYS:0]   db_vec;
   logic              playing, hit;
   logic [GW-1:0]     hit_grp;

   vtc_debounce #(.W(N_KEYS + 1), .DEB_TICKS(DEB_TICKS), .RETRIG_TICKS(RETRIG_TICKS)) u_deb (
      .clk(clk), .rst_n(rst_n), .tick(tick), .long_win(playing),
      .raw({sbt, keys}), .stable(db_vec));

   vtc_keydec #(.N_KEYS(N_KEYS), .N_GROUPS(N_GROUPS)) u_dec (
      .clk(clk), .rst_n(rst_n), .keys(db_vec[N_KEYS-1:0]), .key_map(key_map),
      .hit(hit), .grp(hit_grp));

   vtc_ctrl #(.N_KEYS(N_KEYS), .N_GROUPS(N_GROUPS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .cpu_mode(cpu_mode),
      .db_keys(db_vec[N_KEYS-1:0]), .db_sbt(db_vec[N_KEYS]),
      .hit(hit), .hit_grp(hit_grp),
      .opt_edge(opt_edge), .opt_hold(opt_hold), .opt_retrig(opt_retrig),
      .seq_last(seq_last), .play_done(play_done), .playing(playing),
      .start_o(start_o), .group_o(group_o), .stop_o(stop_o));
endmodule

// File: tb/sim_voice_trig_ctrl.sv
`timescale 1ns/1ps
module sim_voice_trig_ctrl;
   logic         clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic         stop_req = 1'b0, cpu_mode = 1'b0, sbt = 1'b0, play_done = 1'b0;
   logic [7:0]   keys = '0;
   logic [255:0] key_map;
   logic [31:0]  opt_edge, opt_hold, opt_retrig;
   logic [4:0]   seq_last = 5'd31;
   logic         start_o, stop_o;
   logic [4:0]   group_o;

   int n_chk = 0, n_bad = 0, n_start = 0, n_stop = 0, last_grp = -1;

   always #2.5 clk = ~clk;
   always @(negedge clk) tick <= ~tick;

   voice_trig_ctrl #(.DEB_TICKS(4), .RETRIG_TICKS(6)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stop_req(stop_req), .cpu_mode(cpu_mode),
      .keys(keys), .sbt(sbt), .key_map(key_map), .opt_edge(opt_edge),
      .opt_hold(opt_hold), .opt_retrig(opt_retrig), .seq_last(seq_last),
      .play_done(play_done), .start_o(start_o), .group_o(group_o), .stop_o(stop_o));

   always @(negedge clk) begin
      if (start_o) begin n_start++; last_grp = int'(group_o); end
      if (stop_o) n_stop++;
   end

   // {cpu_mode, keys, sbt, expected group}
   localparam logic [14:0] VEC [6] = '{
      {1'b0, 8'h01, 1'b0, 5'd0},
      {1'b0, 8'h06, 1'b0, 5'd5},
      {1'b0, 8'h1F, 1'b0, 5'd30},
      {1'b1, 8'h00, 1'b1, 5'd0},
      {1'b1, 8'h1F, 1'b1, 5'd31},
      {1'b1, 8'hED, 1'b1, 5'd13}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clr();
      n_start = 0; n_stop = 0; last_grp = -1;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press(input logic [7:0] k, input logic s, input int hold);
      @(negedge clk); keys = k; sbt = s;
      wait_cyc(hold);
      keys = '0; sbt = 1'b0;
      wait_cyc(30);
   endtask

   task automatic done_pulse();
      @(negedge clk); play_done = 1'b1;
      @(negedge clk); play_done = 1'b0;
      wait_cyc(5);
   endtask

   initial begin
      #(5.0 * 100000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int g = 0; g < 32; g++) key_map[g*8 +: 8] = 8'(g + 1);
      opt_edge = '1; opt_hold = '0; opt_retrig = '0;
      opt_retrig[7] = 1'b1;
      opt_edge[9]   = 1'b0; opt_hold[9] = 1'b1;
      opt_edge[10]  = 1'b0;
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(20);
      // R1 reset state
      chk("R1 starts after reset", n_start, 0);
      chk("R1 stops after reset", n_stop, 0);

      // R3 / R4 table walk
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); cpu_mode = VEC[i][14];
         wait_cyc(20);
         clr();
         press(VEC[i][13:6], VEC[i][5], 30);
         chk(VEC[i][14] ? "R4 cpu start count" : "R3 key start count", n_start, 1);
         chk(VEC[i][14] ? "R4 cpu group" : "R3 key group", last_grp, int'(VEC[i][4:0]));
         done_pulse();
      end
      // R4 key changes alone start nothing in CPU style
      clr();
      press(8'h03, 1'b0, 30);
      chk("R4 keys without strobe", n_start, 0);
      @(negedge clk); cpu_mode = 1'b0;
      wait_cyc(20);

      // R2 short glitch ignored
      clr();
      press(8'h01, 1'b0, 3);
      chk("R2 glitch ignored", n_start, 0);

      // R5 step sequence with wrap at seq_last=2
      @(negedge clk); seq_last = 5'd2;
      for (int i = 0; i < 4; i++) begin
         clr();
         press(8'h00, 1'b1, 30);
         chk("R5 step start", n_start, 1);
         chk("R5 step group", last_grp, (i == 3) ? 0 : i);
         done_pulse();
      end
      // R6 stop request: stop pulse and pointer rewind
      clr();
      press(8'h00, 1'b1, 30);
      chk("R6 pointer before stop", last_grp, 1);
      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
      wait_cyc(3);
      chk("R6 stop pulse", n_stop, 1);
      clr();
      press(8'h00, 1'b1, 30);
      chk("R6 pointer rewound", last_grp, 0);
      done_pulse();
      // R6 no start while stop_req held
      clr();
      @(negedge clk); stop_req = 1'b1;
      press(8'h01, 1'b0, 30);
      @(negedge clk); stop_req = 1'b0;
      wait_cyc(10);
      chk("R6 start blocked", n_start, 0);

      // R7 non-retriggerable group 5 ignores group 6
      clr();
      @(negedge clk); keys = 8'h06; wait_cyc(30);
      keys = 8'h07; wait_cyc(30);
      keys = 8'h00; wait_cyc(30);
      chk("R7 ignored trigger", n_start, 1);
      chk("R7 group kept", last_grp, 5);
      done_pulse();

      // R8 retriggerable group 7 restarts as group 8
      clr();
      press(8'h08, 1'b0, 30);
      press(8'h09, 1'b0, 30);
      chk("R8 restart count", n_start, 2);
      chk("R8 new group", last_grp, 8);
      chk("R8 no stop", n_stop, 0);
      done_pulse();

      // R9 holdable group 9 stops on release
      clr();
      press(8'h0A, 1'b0, 30);
      chk("R9 start", n_start, 1);
      chk("R9 stop on release", n_stop, 1);

      // R10 level unholdable group 10 repeats while held
      clr();
      @(negedge clk); keys = 8'h0B; wait_cyc(30);
      done_pulse();
      chk("R10 level repeat", n_start, 2);
      @(negedge clk); keys = 8'h00; wait_cyc(30);
      done_pulse();
      chk("R10 no repeat after release", n_start, 2);
      chk("R10 no stop", n_stop, 0);
      // R10 edge group 11 plays once
      clr();
      @(negedge clk); keys = 8'h0C; wait_cyc(30);
      done_pulse();
      chk("R10 edge once", n_start, 1);
      @(negedge clk); keys = 8'h00; wait_cyc(30);
      chk("R11 stop count edge", n_stop, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule